// File: doc/BRIEF.md
# Wiring-Mode Selectable Power Accumulator

This block sums instantaneous real power and squared current for an energy metering front end. Each clock it may receive one signed sample for each of three voltage channels and three current channels, qualified by a valid strobe. A 3-bit wiring code selects how those samples are paired into up to three metering elements. The supported layouts are single-phase two-wire, single-phase three-wire, delta in three- and four-wire forms, and wye with two or three elements. Some layouts pair a voltage with half of the difference of two current channels.

The accumulation interval runs from one frame-end strobe to the next. At frame end the block copies every element power sum and every squared-current sum into output registers and clears the accumulators in the same clock. It raises a one-cycle done pulse. A combinational total adds the three element outputs. The wiring code is taken only at frame end, so the mapping never changes inside an interval. The two reserved codes map nothing and raise an error flag.

Top module: `wiring_power_accum`

## Requirements
- R1: Code 0 (single element, two-wire): element 0 accumulates VA*IA and current channel 0 accumulates IA squared.
- R2: Code 1 (single element, three-wire): element 0 accumulates VA*H(IA-IB), channel 0 accumulates (IA-IB) squared and channel 1 accumulates IB squared.
- R3: Code 2 (three-wire delta): elements 0 and 1 accumulate VA*IA and VB*IB. Channels 0 and 1 accumulate IA and IB squared.
- R4: Code 3 (four-wire delta): elements 0 and 1 accumulate VA*H(IA-IB) and VC*IC. Channels 0, 1 and 2 accumulate the squares of IA-IB, IB and IC.
- R5: Code 4 (two-element wye): elements 0 and 1 accumulate VA*H(IA-IB) and VB*H(IC-IB). Channels 0, 1 and 2 accumulate the squares of IA-IB, IC-IB and IC.
- R6: Code 5 (three-element wye): element k accumulates Vk*Ik and channel k accumulates Ik squared, for the phases A, B and C.
- R7: The total output equals the sum of the three element power outputs.
- R8: An element or current channel that the active code does not use reports zero.
- R9: Codes 6 and 7 are reserved. While one of them is the active code, every sum of that interval is zero and the error output is 1. The error output is 0 for codes 0 to 5.
- R10: A current difference is formed one bit wider than the inputs. H() halves it by an arithmetic right shift, which rounds toward minus infinity: H(-3) = -2 and H(5) = 2.
- R11: The code input is captured only in a frame-end cycle and applies to the interval that cycle opens. Changes to the code input at any other time have no effect.
- R12: The done output is high exactly in the cycle after a frame-end cycle, and the outputs change only then. A sample valid in the frame-end cycle counts toward the new interval and not toward the interval that closes.
- R13: After reset all outputs are zero, done and error are 0, and code 0 is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_i | input | 3 | Wiring code, captured at frame end |
| smp_valid_i | input | 1 | Sample qualifier |
| frame_end_i | input | 1 | Closes the current interval |
| va_i | input | SW | Phase A voltage sample, signed |
| vb_i | input | SW | Phase B voltage sample, signed |
| vc_i | input | SW | Phase C voltage sample, signed |
| ia_i | input | SW | Phase A current sample, signed |
| ib_i | input | SW | Phase B current sample, signed |
| ic_i | input | SW | Phase C current sample, signed |
| pwr0_o | output | AW | Element 0 power sum, signed |
| pwr1_o | output | AW | Element 1 power sum, signed |
| pwr2_o | output | AW | Element 2 power sum, signed |
| pwr_total_o | output | AW+2 | Sum of the element outputs, signed |
| isq0_o | output | AW | Current channel 0 squared sum |
| isq1_o | output | AW | Current channel 1 squared sum |
| isq2_o | output | AW | Current channel 2 squared sum |
| done_o | output | 1 | One-cycle pulse after frame end |
| mode_err_o | output | 1 | Active code is reserved |

## Verification
A sample is consumed by the rising edge at which it is presented. The results of an interval appear one clock after the rising edge that registers frame end, together with done. The error flag reflects the newly captured code from that same edge. The bench drives inputs on the falling edge and keeps its own running sums. At the falling edge that follows each frame-end cycle it compares done, the error flag and all seven sums with the values its sums held before that cycle's sample was added. After the next idle cycle it checks that done has dropped.

// File: rtl/pa_pkg.sv
package pa_pkg;

  localparam int NUM_ELEM = 3;

  typedef enum logic [2:0] {
    WM_1E2W   = 3'd0,
    WM_1E3W   = 3'd1,
    WM_DELTA3 = 3'd2,
    WM_DELTA4 = 3'd3,
    WM_WYE2E  = 3'd4,
    WM_WYE3E  = 3'd5,
    WM_RSV6   = 3'd6,
    WM_RSV7   = 3'd7
  } wmode_e;

  function automatic logic mode_reserved(input wmode_e m);
    return (m == WM_RSV6) || (m == WM_RSV7);
  endfunction

endpackage

// File: rtl/pa_router.sv
module pa_router
  import pa_pkg::*;
#(
  parameter int SW = 16,
  localparam int XW = SW + 1
) (
  input  wmode_e                mode_i,
  input  logic signed [SW-1:0]  va_i,
  input  logic signed [SW-1:0]  vb_i,
  input  logic signed [SW-1:0]  vc_i,
  input  logic signed [SW-1:0]  ia_i,
  input  logic signed [SW-1:0]  ib_i,
  input  logic signed [SW-1:0]  ic_i,
  output logic signed [XW-1:0]  volt_o [NUM_ELEM],
  output logic signed [XW-1:0]  curr_o [NUM_ELEM],
  output logic signed [XW-1:0]  chan_o [NUM_ELEM]
);

  // sign-extend a sample by one bit
  function automatic logic signed [XW-1:0] widen(input logic signed [SW-1:0] s);
    return {s[SW-1], s};
  endfunction

  // difference in the widened domain, cannot overflow
  function automatic logic signed [XW-1:0] diff(input logic signed [SW-1:0] p,
                                                input logic signed [SW-1:0] q);
    return widen(p) - widen(q);
  endfunction

  // arithmetic halving, rounds toward minus infinity
  function automatic logic signed [XW-1:0] halve(input logic signed [XW-1:0] d);
    return d >>> 1;
  endfunction

  logic signed [XW-1:0] xva, xvb, xvc, xia, xib, xic, d_ab, d_cb;

  assign xva  = widen(va_i);
  assign xvb  = widen(vb_i);
  assign xvc  = widen(vc_i);
  assign xia  = widen(ia_i);
  assign xib  = widen(ib_i);
  assign xic  = widen(ic_i);
  assign d_ab = diff(ia_i, ib_i);
  assign d_cb = diff(ic_i, ib_i);

  always_comb begin
    for (int k = 0; k < NUM_ELEM; k++) begin
      volt_o[k] = '0;
      curr_o[k] = '0;
      chan_o[k] = '0;
    end
    case (mode_i)
      WM_1E2W: begin
        volt_o[0] = xva;  curr_o[0] = xia;
        chan_o[0] = xia;
      end
      WM_1E3W: begin
        volt_o[0] = xva;  curr_o[0] = halve(d_ab);
        chan_o[0] = d_ab; chan_o[1] = xib;
      end
      WM_DELTA3: begin
        volt_o[0] = xva;  curr_o[0] = xia;
        volt_o[1] = xvb;  curr_o[1] = xib;
        chan_o[0] = xia;  chan_o[1] = xib;
      end
      WM_DELTA4: begin
        volt_o[0] = xva;  curr_o[0] = halve(d_ab);
        volt_o[1] = xvc;  curr_o[1] = xic;
        chan_o[0] = d_ab; chan_o[1] = xib; chan_o[2] = xic;
      end
      WM_WYE2E: begin
        volt_o[0] = xva;  curr_o[0] = halve(d_ab);
        volt_o[1] = xvb;  curr_o[1] = halve(d_cb);
        chan_o[0] = d_ab; chan_o[1] = d_cb; chan_o[2] = xic;
      end
      WM_WYE3E: begin
        volt_o[0] = xva;  curr_o[0] = xia;
        volt_o[1] = xvb;  curr_o[1] = xib;
        volt_o[2] = xvc;  curr_o[2] = xic;
        chan_o[0] = xia;  chan_o[1] = xib; chan_o[2] = xic;
      end
      default: begin
      end
    endcase
  end

endmodule

// File: rtl/pa_mac.sv
module pa_mac #(
  parameter int XW = 17,
  parameter int AW = 48,
  localparam int PW  = 2 * XW,
  localparam int EXT = AW - PW
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 take_i,
  input  logic                 close_i,
  input  logic signed [XW-1:0] a_i,
  input  logic signed [XW-1:0] b_i,
  output logic signed [AW-1:0] sum_o
);

  function automatic logic signed [AW-1:0] grow(input logic signed [PW-1:0] p);
    return {{EXT{p[PW-1]}}, p};
  endfunction

  logic signed [PW-1:0] prod;
  logic signed [AW-1:0] prod_x;
  logic signed [AW-1:0] acc_q;

  assign prod   = a_i * b_i;
  assign prod_x = take_i ? grow(prod) : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
      sum_o <= '0;
    end else if (close_i) begin
      sum_o <= acc_q;
      acc_q <= prod_x;
    end else begin
      acc_q <= acc_q + prod_x;
    end
  end

endmodule

// File: rtl/pa_frame.sv
module pa_frame
  import pa_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       frame_end_i,
  input  logic [2:0] mode_i,
  output wmode_e     eff_mode_o,
  output wmode_e     act_mode_o,
  output logic       done_o,
  output logic       err_o
);

  wmode_e req_mode;

  assign req_mode   = wmode_e'(mode_i);
  // the sample of a frame-end cycle already belongs to the new interval
  assign eff_mode_o = frame_end_i ? req_mode : act_mode_o;
  assign err_o      = mode_reserved(act_mode_o);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_mode_o <= WM_1E2W;
      done_o     <= 1'b0;
    end else begin
      done_o <= frame_end_i;
      if (frame_end_i) act_mode_o <= req_mode;
    end
  end

endmodule

// File: rtl/wiring_power_accum.sv
module wiring_power_accum
  import pa_pkg::*;
#(
  parameter int SW = 16,
  parameter int ACC_W = 48,
  localparam int XW = SW + 1,
  localparam int TW = ACC_W + 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [2:0]             mode_i,
  input  logic                   smp_valid_i,
  input  logic                   frame_end_i,
  input  logic signed [SW-1:0]   va_i,
  input  logic signed [SW-1:0]   vb_i,
  input  logic signed [SW-1:0]   vc_i,
  input  logic signed [SW-1:0]   ia_i,
  input  logic signed [SW-1:0]   ib_i,
  input  logic signed [SW-1:0]   ic_i,
  output logic signed [ACC_W-1:0] pwr0_o,
  output logic signed [ACC_W-1:0] pwr1_o,
  output logic signed [ACC_W-1:0] pwr2_o,
  output logic signed [TW-1:0]    pwr_total_o,
  output logic [ACC_W-1:0]        isq0_o,
  output logic [ACC_W-1:0]        isq1_o,
  output logic [ACC_W-1:0]        isq2_o,
  output logic                    done_o,
  output logic                    mode_err_o
);

  function automatic logic signed [TW-1:0] sum3(input logic signed [ACC_W-1:0] x,
                                               input logic signed [ACC_W-1:0] y,
                                               input logic signed [ACC_W-1:0] z);
    logic signed [TW-1:0] ex, ey, ez;
    ex = {{2{x[ACC_W-1]}}, x};
    ey = {{2{y[ACC_W-1]}}, y};
    ez = {{2{z[ACC_W-1]}}, z};
    return ex + ey + ez;
  endfunction

  wmode_e eff_mode;
  wmode_e act_mode;

  logic signed [XW-1:0]    volt [NUM_ELEM];
  logic signed [XW-1:0]    curr [NUM_ELEM];
  logic signed [XW-1:0]    chan [NUM_ELEM];
  logic signed [ACC_W-1:0] p_sum [NUM_ELEM];
  logic signed [ACC_W-1:0] q_sum [NUM_ELEM];

  pa_frame u_frame (
    .clk        (clk),
    .rst_n      (rst_n),
    .frame_end_i(frame_end_i),
    .mode_i     (mode_i),
    .eff_mode_o (eff_mode),
    .act_mode_o (act_mode),
    .done_o     (done_o),
    .err_o      (mode_err_o)
  );

  pa_router #(.SW(SW)) u_route (
    .mode_i(eff_mode),
    .va_i  (va_i),
    .vb_i  (vb_i),
    .vc_i  (vc_i),
    .ia_i  (ia_i),
    .ib_i  (ib_i),
    .ic_i  (ic_i),
    .volt_o(volt),
    .curr_o(curr),
    .chan_o(chan)
  );

  for (genvar g = 0; g < NUM_ELEM; g++) begin : g_elem
    pa_mac #(.XW(XW), .AW(ACC_W)) u_pwr (
      .clk    (clk),
      .rst_n  (rst_n),
      .take_i (smp_valid_i),
      .close_i(frame_end_i),
      .a_i    (volt[g]),
      .b_i    (curr[g]),
      .sum_o  (p_sum[g])
    );
    pa_mac #(.XW(XW), .AW(ACC_W)) u_isq (
      .clk    (clk),
      .rst_n  (rst_n),
      .take_i (smp_valid_i),
      .close_i(frame_end_i),
      .a_i    (chan[g]),
      .b_i    (chan[g]),
      .sum_o  (q_sum[g])
    );
  end

  assign pwr0_o      = p_sum[0];
  assign pwr1_o      = p_sum[1];
  assign pwr2_o      = p_sum[2];
  assign isq0_o      = q_sum[0];
  assign isq1_o      = q_sum[1];
  assign isq2_o      = q_sum[2];
  assign pwr_total_o = sum3(p_sum[0], p_sum[1], p_sum[2]);

endmodule

// File: rtl/pa_checker.sv
module pa_checker #(
  parameter int AW = 48
) (
  input logic          clk,
  input logic          rst_n,
  input logic          frame_end_i,
  input logic          done_o,
  input logic          mode_err_o,
  input logic [2:0]    act_mode,
  input logic [AW-1:0] p0,
  input logic [AW-1:0] p1,
  input logic [AW-1:0] p2,
  input logic [AW-1:0] q0,
  input logic [AW-1:0] q1,
  input logic [AW-1:0] q2
);

  AST_DONE_AFTER_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    done_o == $past(frame_end_i)); // R12

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(frame_end_i) |-> ($stable(p0) && $stable(p1) && $stable(p2) &&
                             $stable(q0) && $stable(q1) && $stable(q2))); // R12

  AST_MODE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(frame_end_i) |-> $stable(act_mode)); // R11

  AST_RSV_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && $past(mode_err_o)) |->
      (p0 == '0 && p1 == '0 && p2 == '0 && q0 == '0 && q1 == '0 && q2 == '0)); // R9

  AST_UNUSED_ELEM2: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && $past(act_mode) != 3'd5) |->
      (p2 == '0 && ($past(act_mode) > 3'd2 || q2 == '0))); // R8

endmodule

bind wiring_power_accum pa_checker #(.AW(ACC_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .frame_end_i(frame_end_i),
  .done_o     (done_o),
  .mode_err_o (mode_err_o),
  .act_mode   (act_mode),
  .p0         (pwr0_o),
  .p1         (pwr1_o),
  .p2         (pwr2_o),
  .q0         (isq0_o),
  .q1         (isq1_o),
  .q2         (isq2_o)
);

// File: tb/sim_wiring_power_accum.sv
module sim_wiring_power_accum;

  localparam int CLK_PERIOD = 10;
  localparam int SW = 16;
  localparam int AW = 48;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [2:0] mode_i = '0;
  logic smp_valid_i = 1'b0;
  logic frame_end_i = 1'b0;
  logic signed [SW-1:0] va_i = '0, vb_i = '0, vc_i = '0;
  logic signed [SW-1:0] ia_i = '0, ib_i = '0, ic_i = '0;
  logic signed [AW-1:0] pwr0_o, pwr1_o, pwr2_o;
  logic signed [AW+1:0] pwr_total_o;
  logic [AW-1:0] isq0_o, isq1_o, isq2_o;
  logic done_o, mode_err_o;

  always #(CLK_PERIOD/2) clk = ~clk;

  wiring_power_accum #(.SW(SW), .ACC_W(AW)) u0 (.*);

  int checks = 0;
  int failures = 0;
  longint acc_p [3];
  longint acc_q [3];
  int cur_mode = 0;

  // floor of d/2 written without shifts
  function automatic longint hf(longint d);
    if (d >= 0) return d / 2;
    return -((-d + 1) / 2);
  endfunction

  function automatic int n_elem(int m);
    case (m)
      0, 1: return 1;
      2, 3, 4: return 2;
      5: return 3;
      default: return 0;
    endcase
  endfunction

  function automatic int n_chan(int m);
    case (m)
      0: return 1;
      1, 2: return 2;
      3, 4, 5: return 3;
      default: return 0;
    endcase
  endfunction

  function automatic longint e_pow(int m, int k, longint va, longint vb, longint vc,
                                   longint ia, longint ib, longint ic);
    longint v [3];
    longint i [3];
    v = '{va, vb, vc};
    i = '{ia, ib, ic};
    if (k >= n_elem(m)) return 0;
    case (m)
      1: return va * hf(ia - ib);
      3: return (k == 0) ? va * hf(ia - ib) : vc * ic;
      4: return (k == 0) ? va * hf(ia - ib) : vb * hf(ic - ib);
      default: return v[k] * i[k];
    endcase
  endfunction

  function automatic longint e_chan(int m, int k, longint ia, longint ib, longint ic);
    longint i [3];
    i = '{ia, ib, ic};
    if (k >= n_chan(m)) return 0;
    if ((m == 1 || m == 3 || m == 4) && k == 0) return ia - ib;
    if (m == 4 && k == 1) return ic - ib;
    return i[k];
  endfunction

  function automatic string tag_of(int m);
    case (m)
      0: return "R1";
      1: return "R2";
      2: return "R3";
      3: return "R4";
      4: return "R5";
      5: return "R6";
      default: return "R9";
    endcase
  endfunction

  function automatic int rs();
    return int'($urandom_range(65535, 0)) - 32768;
  endfunction

  task automatic chk(input string tag, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // one input cycle; a frame-end cycle is followed by the result checks
  task automatic put(input bit fe, input int md, input bit vld,
                     input int sva, input int svb, input int svc,
                     input int sia, input int sib, input int sic);
    longint sp [3];
    longint sq [3];
    longint act_p [3];
    longint act_q [3];
    longint tot;
    int use_mode, old_mode;
    string tg;
    @(negedge clk);
    frame_end_i = fe;
    mode_i      = md[2:0];
    smp_valid_i = vld;
    va_i = sva[SW-1:0]; vb_i = svb[SW-1:0]; vc_i = svc[SW-1:0];
    ia_i = sia[SW-1:0]; ib_i = sib[SW-1:0]; ic_i = sic[SW-1:0];
    old_mode = cur_mode;
    use_mode = fe ? md : cur_mode;   // R11: only a frame-end cycle changes the mapping
    if (fe) begin
      for (int k = 0; k < 3; k++) begin
        sp[k] = acc_p[k]; sq[k] = acc_q[k];
        acc_p[k] = 0; acc_q[k] = 0;
      end
      cur_mode = md;
    end
    if (vld) begin
      for (int k = 0; k < 3; k++) begin
        longint c;
        acc_p[k] += e_pow(use_mode, k, sva, svb, svc, sia, sib, sic);
        c = e_chan(use_mode, k, sia, sib, sic);
        acc_q[k] += c * c;
      end
    end
    if (fe) begin
      @(negedge clk);
      frame_end_i = 1'b0;
      smp_valid_i = 1'b0;
      act_p = '{longint'(pwr0_o), longint'(pwr1_o), longint'(pwr2_o)};
      act_q = '{longint'(isq0_o), longint'(isq1_o), longint'(isq2_o)};
      chk("R12", "done after frame end", longint'(done_o), 1);
      chk("R9", "error flag", longint'(mode_err_o), (md >= 6) ? 1 : 0);
      tot = 0;
      for (int k = 0; k < 3; k++) begin
        tg = (old_mode < 6 && k >= n_elem(old_mode)) ? "R8" : tag_of(old_mode);
        chk(tg, $sformatf("element %0d power", k), act_p[k], sp[k]);
        tg = (old_mode < 6 && k >= n_chan(old_mode)) ? "R8" : tag_of(old_mode);
        chk(tg, $sformatf("channel %0d isq", k), act_q[k], sq[k]);
        tot += sp[k];
      end
      chk("R7", "total power", longint'(pwr_total_o), tot);
    end
  endtask

  task automatic rnd_cycle(input bit vld);
    // mode_i wanders mid-interval; the model ignores it (R11)
    put(1'b0, int'($urandom_range(7, 0)), vld, rs(), rs(), rs(), rs(), rs(), rs());
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", checks, 0);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin : stim
    void'($urandom(32'd1234));
    for (int k = 0; k < 3; k++) begin acc_p[k] = 0; acc_q[k] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R13 reset state
    chk("R13", "pwr0 reset", longint'(pwr0_o), 0);
    chk("R13", "total reset", longint'(pwr_total_o), 0);
    chk("R13", "isq0 reset", longint'(isq0_o), 0);
    chk("R13", "done reset", longint'(done_o), 0);
    chk("R13", "error reset", longint'(mode_err_o), 0);

    // first interval runs with the reset code 0 (R13)
    for (int n = 0; n < 5; n++) rnd_cycle(1'b1);
    put(1'b1, 1, 1'b0, 0, 0, 0, 0, 0, 0);

    // R10: H(-3) = -2 and H(5) = 2 under code 1
    put(1'b0, 1, 1'b1, 1, 0, 0, -1, 2, 0);
    put(1'b1, 1, 1'b0, 0, 0, 0, 0, 0, 0);
    chk("R10", "VA*H(-3) with VA=1", longint'(pwr0_o), -2);
    put(1'b0, 1, 1'b1, 3, 0, 0, 5, 0, 0);
    chk("R12", "done dropped after idle", longint'(done_o), 0);
    put(1'b1, 5, 1'b1, 7, 8, 9, -10, 11, 12);   // R12: this sample opens the code 5 interval
    chk("R10", "VA*H(5) with VA=3", longint'(pwr0_o), 6);

    // R11: code input changes mid-interval have no effect
    put(1'b0, 0, 1'b1, 100, -200, 300, 4, 5, -6);
    put(1'b0, 7, 1'b1, -30000, 30000, -32768, 32767, -32768, 32767);
    put(1'b1, 2, 1'b1, 1, 2, 3, 4, 5, 6);
    put(1'b1, 3, 1'b1, -1, -2, -3, -4, -5, -6);   // back-to-back frame ends
    put(1'b1, 4, 1'b0, 0, 0, 0, 0, 0, 0);

    // constrained random intervals over all codes
    for (int it = 0; it < 40; it++) begin
      int nxt;
      int len;
      len = int'($urandom_range(20, 1));
      for (int n = 0; n < len; n++) rnd_cycle($urandom_range(3, 0) != 0);
      nxt = ($urandom_range(7, 0) == 0) ? int'($urandom_range(7, 6)) : int'($urandom_range(5, 0));
      put(1'b1, nxt, $urandom_range(1, 0) == 1, rs(), rs(), rs(), rs(), rs(), rs());
    end

    // R9: both reserved codes, with samples present
    put(1'b1, 6, 1'b1, 500, 600, 700, 800, 900, 1000);
    for (int n = 0; n < 4; n++) rnd_cycle(1'b1);
    put(1'b1, 7, 1'b1, 5, 6, 7, 8, 9, 10);
    for (int n = 0; n < 4; n++) rnd_cycle(1'b1);
    put(1'b1, 5, 1'b0, 0, 0, 0, 0, 0, 0);
    for (int n = 0; n < 3; n++) rnd_cycle(1'b1);
    put(1'b1, 0, 1'b0, 0, 0, 0, 0, 0, 0);

    repeat (2) @(negedge clk);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule